// File: doc/BRIEF.md
# Supervisor Domain Protection Control Registers

This block holds two machine-mode control registers for a hart's supervisor-domain protection. The first is the protection-table register. It carries the root page number of the protection tables, a supervisor domain identifier (SDID) and a protection mode. The second is a 32-bit domain configuration register with per-domain control bits. Both registers sit behind a single-request CSR port. Each request carries the requester's privilege level and returns registered read data and an illegal-access flag one cycle later.

Every write is legalized field by field. A mode the build does not support leaves the stored mode unchanged. Only the low `SDID_BITS` bits of the SDID can be set. If the resulting mode is Bare, the SDID and page number are forced to zero. Reserved bits are never stored.

The stored page number, SDID and mode are driven continuously to the protection logic. A separate registered `prot_active` flag follows the effective privilege mode. The register width is set by `XLEN`, which may be 32 or 64.

Top module: `sdprot_csr`

## Requirements
- R1: A synchronous reset clears both registers, which selects Bare mode (0). After reset, `prot_ppn`, `prot_sdid`, `prot_mode`, `dom_cfg`, `csr_rdata`, `csr_illegal` and `prot_active` are all zero.
- R2: Privilege encoding is 0 = U, 1 = S, 3 = M, and 2 is treated as not M. A request with `csr_priv` other than 3 sets `csr_illegal` in the next cycle, returns zero read data, and leaves both registers unchanged.
- R3: Protection-table register layout. For XLEN=32: page number in bits 21:0, SDID in bits 29:24, mode in bits 31:30. For XLEN=64: page number in bits 43:0, SDID in bits 59:54, mode in bits 63:60. An M-mode write with a supported non-Bare mode stores the fields, and a read returns them in this layout.
- R4: Supported modes are 0 and 1 for XLEN=32, and 0, 1 and 2 for XLEN=64. A write carrying any other mode keeps the previous mode, and the other fields are still legalized and written.
- R5: Only SDID bits `SDID_BITS-1:0` are stored. The higher SDID bits read as zero, so writing all ones and reading back reveals `SDID_BITS`.
- R6: Whenever the stored mode is Bare, SDID and page number are zero. This holds both for a write of mode 0 and for an unsupported mode written while the register is in Bare mode.
- R7: Reserved bits read as zero. These are bits 23:22 (XLEN=32) or 53:44 (XLEN=64) of the protection-table register, and bits 19:9 of the configuration register.
- R8: Configuration register layout: bits 5:0 interrupt-controller select, bit 6 QoS-enable, bit 7 external-debug allow, bit 8 external-trace allow, bits 23:20 resource-limit field, bits 27:24 monitoring field, bits 31:28 QoS identifier. An M-mode write stores these fields and drives them on `dom_cfg`. For XLEN=64, read bits above 31 are zero.
- R9: `prot_active` is 1 in the cycle after `eff_priv` is anything other than 3 (M), and 0 in the cycle after it is 3.
- R10: A legal read response appears one cycle after the request and returns the value from before that request's write. The written value reaches the live outputs in that same next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Access request this cycle |
| csr_we | input | 1 | Request is a write |
| csr_sel | input | 1 | 0 = protection-table register, 1 = configuration register |
| csr_priv | input | 2 | Privilege of the requester |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data (old value) |
| csr_illegal | output | 1 | Registered illegal-access flag |
| eff_priv | input | 2 | Effective privilege mode for protection |
| prot_ppn | output | 22 or 44 | Live root page number |
| prot_sdid | output | 6 | Live SDID |
| prot_mode | output | 2 or 4 | Live protection mode |
| prot_active | output | 1 | Protection register active |
| dom_cfg | output | 32 | Live configuration register |

## Verification
The hardest state to reach is an unsupported mode arriving while the register is already in Bare mode. Here the kept mode forces the freshly written SDID and page number back to zero, even though the write data carries non-zero fields. The vector table reaches it by first writing Bare, then writing mode 2 with SDID and page bits set, and reading back zero. A companion vector writes an unsupported mode while in mode 1 and shows the fields landing under the retained mode. Read-before-write ordering is checked by writing over a known value and comparing the response with that old value.

// File: rtl/sdprot_pkg.sv
package sdprot_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam int CFG_W = 32;
  localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'hFFF0_01FF;
  localparam int SDID_MAX = 6;
endpackage

// File: rtl/sdprot_gate.sv
module sdprot_gate
  import sdprot_pkg::*;
(
  input  logic       req,
  input  logic       we,
  input  logic       sel,
  input  logic [1:0] priv,
  output logic       rd_ok,
  output logic       wr_tbl,
  output logic       wr_cfg,
  output logic       fault
);
  logic is_m;
  always_comb begin
    is_m   = (priv == PRIV_M);
    rd_ok  = req && is_m;
    fault  = req && !is_m;
    wr_tbl = req && we && is_m && !sel;
    wr_cfg = req && we && is_m && sel;
  end
endmodule

// File: rtl/sdprot_tbl_legal.sv
module sdprot_tbl_legal
  import sdprot_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int SDID_BITS = 6,
  localparam int PPN_W    = (XLEN == 64) ? 44 : 22,
  localparam int MODE_W   = (XLEN == 64) ? 4 : 2,
  localparam int MODE_LSB = XLEN - MODE_W,
  localparam int SDID_LSB = MODE_LSB - SDID_MAX
)(
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic [XLEN-1:0]     wdata,
  output logic [MODE_W-1:0]   nxt_mode,
  output logic [SDID_MAX-1:0] nxt_sdid,
  output logic [PPN_W-1:0]    nxt_ppn
);
  localparam logic [SDID_MAX-1:0] SDID_MASK =
    SDID_MAX'((7'd1 << SDID_BITS) - 7'd1);

  logic [MODE_W-1:0] w_mode;
  logic              w_mode_ok;

  assign w_mode = wdata[MODE_LSB +: MODE_W];

  generate
    if (XLEN == 64) begin : g_x64
      assign w_mode_ok = (w_mode <= MODE_W'(2));
    end else begin : g_x32
      assign w_mode_ok = (w_mode <= MODE_W'(1));
    end
  endgenerate

  always_comb begin
    nxt_mode = w_mode_ok ? w_mode : cur_mode;
    if (nxt_mode == '0) begin
      nxt_sdid = '0;
      nxt_ppn  = '0;
    end else begin
      nxt_sdid = wdata[SDID_LSB +: SDID_MAX] & SDID_MASK;
      nxt_ppn  = wdata[PPN_W-1:0];
    end
  end
endmodule

// File: rtl/sdprot_cfg_legal.sv
module sdprot_cfg_legal
  import sdprot_pkg::*;
(
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] nxt_cfg
);
  assign nxt_cfg = wdata & CFG_KEEP_MASK;
endmodule

// File: rtl/sdprot_csr.sv
module sdprot_csr
  import sdprot_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int SDID_BITS = 6,
  localparam int PPN_W    = (XLEN == 64) ? 44 : 22,
  localparam int MODE_W   = (XLEN == 64) ? 4 : 2,
  localparam int MODE_LSB = XLEN - MODE_W,
  localparam int SDID_LSB = MODE_LSB - SDID_MAX
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_req,
  input  logic                csr_we,
  input  logic                csr_sel,
  input  logic [1:0]          csr_priv,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata,
  output logic                csr_illegal,
  input  logic [1:0]          eff_priv,
  output logic [PPN_W-1:0]    prot_ppn,
  output logic [SDID_MAX-1:0] prot_sdid,
  output logic [MODE_W-1:0]   prot_mode,
  output logic                prot_active,
  output logic [CFG_W-1:0]    dom_cfg
);
  logic rd_ok, wr_tbl, wr_cfg, fault;
  logic [MODE_W-1:0]   nxt_mode;
  logic [SDID_MAX-1:0] nxt_sdid;
  logic [PPN_W-1:0]    nxt_ppn;
  logic [CFG_W-1:0]    nxt_cfg;
  logic [XLEN-1:0]     tbl_view, cfg_view, rd_sel;

  sdprot_gate u_gate (
    .req(csr_req), .we(csr_we), .sel(csr_sel), .priv(csr_priv),
    .rd_ok(rd_ok), .wr_tbl(wr_tbl), .wr_cfg(wr_cfg), .fault(fault)
  );

  sdprot_tbl_legal #(.XLEN(XLEN), .SDID_BITS(SDID_BITS)) u_tbl (
    .cur_mode(prot_mode), .wdata(csr_wdata),
    .nxt_mode(nxt_mode), .nxt_sdid(nxt_sdid), .nxt_ppn(nxt_ppn)
  );

  sdprot_cfg_legal u_cfg (
    .wdata(csr_wdata[CFG_W-1:0]), .nxt_cfg(nxt_cfg)
  );

  always_comb begin
    tbl_view = '0;
    tbl_view[PPN_W-1:0]              = prot_ppn;
    tbl_view[SDID_LSB +: SDID_MAX]   = prot_sdid;
    tbl_view[MODE_LSB +: MODE_W]     = prot_mode;
    cfg_view = '0;
    cfg_view[CFG_W-1:0]              = dom_cfg;
    rd_sel   = csr_sel ? cfg_view : tbl_view;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_ppn    <= '0;
      prot_sdid   <= '0;
      prot_mode   <= '0;
      dom_cfg     <= '0;
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
      prot_active <= 1'b0;
    end else begin
      if (wr_tbl) begin
        prot_mode <= nxt_mode;
        prot_sdid <= nxt_sdid;
        prot_ppn  <= nxt_ppn;
      end
      if (wr_cfg) dom_cfg <= nxt_cfg;
      csr_rdata   <= rd_ok ? rd_sel : '0;
      csr_illegal <= fault;
      prot_active <= (eff_priv != PRIV_M);
    end
  end
endmodule

// File: rtl/sdprot_csr_chk.sv
module sdprot_csr_chk
  import sdprot_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int SDID_BITS = 6,
  localparam int PPN_W    = (XLEN == 64) ? 44 : 22,
  localparam int MODE_W   = (XLEN == 64) ? 4 : 2
)(
  input logic                clk,
  input logic                rst,
  input logic                csr_req,
  input logic [1:0]          csr_priv,
  input logic [XLEN-1:0]     csr_rdata,
  input logic                csr_illegal,
  input logic [1:0]          eff_priv,
  input logic [PPN_W-1:0]    prot_ppn,
  input logic [SDID_MAX-1:0] prot_sdid,
  input logic [MODE_W-1:0]   prot_mode,
  input logic                prot_active,
  input logic [CFG_W-1:0]    dom_cfg
);
  localparam logic [SDID_MAX-1:0] HI_MASK =
    ~SDID_MAX'((7'd1 << SDID_BITS) - 7'd1);
  localparam logic [MODE_W-1:0] MODE_TOP = (XLEN == 64) ? MODE_W'(2) : MODE_W'(1);

  // R2
  unpriv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_priv != PRIV_M) |=> (csr_illegal && csr_rdata == '0));
  // R2
  unpriv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_priv != PRIV_M) |=>
      ($stable(prot_mode) && $stable(prot_sdid) && $stable(prot_ppn) && $stable(dom_cfg)));
  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    prot_mode <= MODE_TOP);
  // R5
  sdid_width_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_sdid & HI_MASK) == '0);
  // R6
  bare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_mode == '0) |-> (prot_sdid == '0 && prot_ppn == '0));
  // R7
  cfg_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    dom_cfg[19:9] == '0);
  // R9
  active_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(eff_priv) |=> (prot_active == ($past(eff_priv) != PRIV_M)));
endmodule

bind sdprot_csr sdprot_csr_chk #(.XLEN(XLEN), .SDID_BITS(SDID_BITS)) u_chk (
  .clk(clk), .rst(rst), .csr_req(csr_req), .csr_priv(csr_priv),
  .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .eff_priv(eff_priv),
  .prot_ppn(prot_ppn), .prot_sdid(prot_sdid), .prot_mode(prot_mode),
  .prot_active(prot_active), .dom_cfg(dom_cfg)
);

// File: tb/sdprot_csr_tb.sv
module sdprot_csr_tb;
  localparam int XLEN = 32;
  localparam int SDID_BITS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_req = 1'b0, csr_we = 1'b0, csr_sel = 1'b0;
  logic [1:0]  csr_priv = 2'd3, eff_priv = 2'd3;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic [21:0] prot_ppn;
  logic [5:0]  prot_sdid;
  logic [1:0]  prot_mode;
  logic        prot_active;
  logic [31:0] dom_cfg;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_rd;
  logic        got_ill;

  always #10 clk = ~clk;

  sdprot_csr #(.XLEN(XLEN), .SDID_BITS(SDID_BITS)) u_dut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_priv(csr_priv), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .eff_priv(eff_priv), .prot_ppn(prot_ppn),
    .prot_sdid(prot_sdid), .prot_mode(prot_mode), .prot_active(prot_active),
    .dom_cfg(dom_cfg)
  );

  typedef struct packed {
    logic [1:0]  priv;
    logic        sel;
    logic [31:0] wdata;
    logic        ill;
    logic [31:0] rb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 32'h7FFF_FFFF, 1'b0, 32'h4F3F_FFFF}, // R3 R5 R7
    '{2'd3, 1'b0, 32'hC012_3456, 1'b0, 32'h4012_3456}, // R4 keep mode 1
    '{2'd1, 1'b0, 32'h4100_0001, 1'b1, 32'h4012_3456}, // R2 S-mode
    '{2'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000}, // R2 U-mode
    '{2'd3, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'hFFF0_01FF}, // R7 R8
    '{2'd3, 1'b0, 32'h0A00_00FF, 1'b0, 32'h0000_0000}, // R6 Bare write
    '{2'd3, 1'b0, 32'hB500_0ABC, 1'b0, 32'h0000_0000}, // R4 R6 unsupported in Bare
    '{2'd3, 1'b0, 32'h45AB_CDEF, 1'b0, 32'h452B_CDEF}, // R3 R5 R7
    '{2'd3, 1'b1, 32'h1234_5678, 1'b0, 32'h1230_0078}, // R8
    '{2'd2, 1'b0, 32'h4000_0000, 1'b1, 32'h452B_CDEF}  // R2 reserved priv
  };

  task automatic op(input logic [1:0] p, input logic we, input logic sel,
                    input logic [31:0] wd);
    csr_req = 1'b1; csr_we = we; csr_sel = sel; csr_priv = p; csr_wdata = wd;
    @(negedge clk);
    got_rd = csr_rdata; got_ill = csr_illegal;
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(prot_mode), 0);
    chk("R1 sdid", 32'(prot_sdid), 0);
    chk("R1 ppn", 32'(prot_ppn), 0);
    chk("R1 cfg", dom_cfg, 0);
    chk("R1 active", 32'(prot_active), 0);
    chk("R1 illegal", 32'(csr_illegal), 0);
    op(2'd3, 1'b0, 1'b0, '0);
    chk("R1 read tbl", got_rd, 0);

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].priv, 1'b1, VECS[i].sel, VECS[i].wdata);
      chk("R2 illegal flag", 32'(got_ill), 32'(VECS[i].ill));
      if (VECS[i].ill) chk("R2 zero rdata", got_rd, 0);
      op(2'd3, 1'b0, VECS[i].sel, '0);
      chk("R3-R8 readback", got_rd, VECS[i].rb);
    end

    // R10 read-before-write and live outputs
    op(2'd3, 1'b1, 1'b0, 32'h7FFF_FFFF);
    chk("R10 old value", got_rd, 32'h452B_CDEF);
    chk("R10 illegal", 32'(got_ill), 0);
    chk("R3 live mode", 32'(prot_mode), 1);
    chk("R5 live sdid", 32'(prot_sdid), 32'hF);
    chk("R3 live ppn", 32'(prot_ppn), 32'h3F_FFFF);
    chk("R8 live cfg", dom_cfg, 32'h1230_0078);

    // R9 active follows effective privilege
    eff_priv = 2'd1; @(negedge clk);
    chk("R9 S active", 32'(prot_active), 1);
    eff_priv = 2'd0; @(negedge clk);
    chk("R9 U active", 32'(prot_active), 1);
    eff_priv = 2'd3; @(negedge clk);
    chk("R9 M inactive", 32'(prot_active), 0);

    // R1 reset clears a loaded state
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 rereset mode", 32'(prot_mode), 0);
    chk("R1 rereset cfg", dom_cfg, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule